// File: doc/BRIEF.md
# Cascaded FIFO Depth-Expansion Token Ring Controller

This block holds the control logic that lets several identical FIFO slices act as one deeper FIFO. Write ownership and read ownership each move around a ring of slices as a token. A slice accepts writes only while it holds the write token and supplies reads only while it holds the read token. When the owner finishes its last location, it pulses its pass output, and the next slice in the ring takes ownership on the following cycle. A lead-select input picks which slice holds both tokens when reset ends. The storage arrays are outside the block. The block drives one-hot write and read strobes, one slot address per direction, and the full and empty flags for the whole ring.

In cascade mode each slice's write pass output carries its write token pulse. In standalone mode (`cascade_en` low) the same output carries that slice's half-full flag. Tokens never move in standalone mode, so the lead slice works alone and wraps over its own locations. Each token engine is a state machine with three states. IDLE means the slice does not own the token. HOLD means it owns the token and is below its final location. LAST means it owns the token and sits at its final location. There are four transitions:

- IDLE to HOLD when a pass pulse arrives in cascade mode.
- HOLD to LAST when a transfer is accepted at the second-to-last location.
- LAST to IDLE when a transfer is accepted there in cascade mode. This is the pass.
- LAST to HOLD when a transfer is accepted there in standalone mode. This is the wrap.

The occupancy tracker has three states: EMPTY, MID and FULL. EMPTY goes to MID on a write. MID goes to FULL on a write alone at capacity minus one. MID goes to EMPTY on a read alone at one entry. FULL goes to MID on a read.

Top module: `fifo_ring_ctrl`

## Requirements
- R1: In the cycle after a synchronous reset (`rst_n` low at a clock edge), the state is as follows:
  - the slice indexed by `lead_sel` owns both tokens;
  - both addresses are 0;
  - `empty`=1 and `full`=0;
  - in cascade mode no pass output is high.
- R2: An accepted write raises exactly one bit of `wr_slice_en`: bit i, where i is the write-token owner. `wr_addr` shows the owner's slot, which advances by one after each accepted write. The same rules apply to reads with `rd_slice_en` and `rd_addr`.
- R3: In cascade mode, an accepted write at slot SLICE_DEPTH-1 raises `wr_pass_out[i]` of the owner i in that same cycle. Slice (i+1) mod NUM_SLICES then owns the write token from the next cycle, at slot 0. Slice NUM_SLICES-1 passes to slice 0.
- R4: In cascade mode, an accepted read at slot SLICE_DEPTH-1 raises `rd_pass_out[i]` in that same cycle and passes the read token around the ring in the same way.
- R5: Capacity is NUM_SLICES*SLICE_DEPTH in cascade mode and SLICE_DEPTH in standalone mode.
  - `full`=1 exactly at capacity and `empty`=1 exactly at zero entries.
  - A write request while `full` is ignored: no strobe, and the count is unchanged.
  - A read request while `empty` is ignored in the same way.
  - Requests at slices without the token never reach a slice.
- R6: Reads visit (slice, slot) pairs in exactly the order in which writes filled them, so the ring behaves as one FIFO.
- R7: In standalone mode the tokens never leave the lead slice and its addresses wrap from SLICE_DEPTH-1 to 0. `wr_pass_out[i]` is 1 when slice i holds more than SLICE_DEPTH/2 entries, and `rd_pass_out` stays 0.
- R8: In cascade mode no pass pulse appears after reset except in a cycle with an accepted transfer at a final slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cascade_en | input | 1 | 1: ring cascade; 0: standalone with half-full on pass outputs (static after reset) |
| lead_sel | input | SEL_W | Index of the slice that owns both tokens after reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| wr_slice_en | output | NUM_SLICES | One-hot write strobe to the owning slice |
| wr_addr | output | AW | Write slot within the owning slice |
| rd_slice_en | output | NUM_SLICES | One-hot read strobe to the owning slice |
| rd_addr | output | AW | Read slot within the owning slice |
| full | output | 1 | Ring holds capacity entries |
| empty | output | 1 | Ring holds no entries |
| wr_pass_out | output | NUM_SLICES | Write token pulse per slice (cascade) or half-full flag (standalone) |
| rd_pass_out | output | NUM_SLICES | Read token pulse per slice (cascade only) |

## Verification
The hardest situation to reach is a full ring in which both tokens sit in the same slice at the wrap from the last slice back to the first, while a read and a write arrive together. It needs an exact number of transfers after a reset whose lead slice is not slice 0. A directed sequence fills the ring completely from lead slice 2, tries an extra write and drains it. Random phases biased towards writes and then towards reads repeatedly push the count to both limits with concurrent requests. A bench model of slot contents checks the read order.

// File: rtl/fifo_ring_pkg.sv
package fifo_ring_pkg;

    // token engine states
    typedef enum logic [1:0] {
        TK_IDLE = 2'd0,
        TK_HOLD = 2'd1,
        TK_LAST = 2'd2
    } tok_state_t;

    // ring occupancy states
    typedef enum logic [1:0] {
        FL_EMPTY = 2'd0,
        FL_MID   = 2'd1,
        FL_FULL  = 2'd2
    } fill_state_t;

endpackage

// File: rtl/token_fsm.sv
module token_fsm
    import fifo_ring_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lead,
    input  logic          cascade_en,
    input  logic          tok_in,
    input  logic          xfer,
    output logic          owner,
    output logic [AW-1:0] slot,
    output logic          tok_out
);

    localparam logic [AW-1:0] SLOT_LAST = AW'(DEPTH - 1);
    localparam logic [AW-1:0] SLOT_PRE  = AW'(DEPTH - 2);

    tok_state_t state_q, state_d;
    logic       fire;

    assign fire = xfer && (state_q != TK_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= lead ? TK_HOLD : TK_IDLE;
        else        state_q <= state_d;
    end

    // slot counter, wraps at the final slot
    always_ff @(posedge clk) begin
        if (!rst_n)    slot <= '0;
        else if (fire) slot <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TK_IDLE: if (cascade_en && tok_in) state_d = TK_HOLD;
            TK_HOLD: if (fire && slot == SLOT_PRE) state_d = TK_LAST;
            TK_LAST: if (fire) state_d = cascade_en ? TK_IDLE : TK_HOLD;
            default: state_d = TK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        owner   = (state_q != TK_IDLE);
        tok_out = (state_q == TK_LAST) && fire && cascade_en;
    end

endmodule

// File: rtl/ring_slice.sv
module ring_slice #(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int OW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lead,
    input  logic          cascade_en,
    input  logic          wr_pass_in,
    input  logic          rd_pass_in,
    input  logic          wr_go,
    input  logic          rd_go,
    output logic          wr_own,
    output logic          rd_own,
    output logic          wr_strobe,
    output logic          rd_strobe,
    output logic [AW-1:0] wr_slot,
    output logic [AW-1:0] rd_slot,
    output logic          wr_pass_out,
    output logic          rd_pass_out
);

    localparam logic [OW-1:0] HALF = OW'(DEPTH / 2);

    logic          wtok, rtok;
    logic [OW-1:0] occ_q;
    logic          half_full;

    token_fsm #(.DEPTH(DEPTH)) u_wr_tok (
        .clk(clk), .rst_n(rst_n), .lead(lead), .cascade_en(cascade_en),
        .tok_in(wr_pass_in), .xfer(wr_go),
        .owner(wr_own), .slot(wr_slot), .tok_out(wtok)
    );

    token_fsm #(.DEPTH(DEPTH)) u_rd_tok (
        .clk(clk), .rst_n(rst_n), .lead(lead), .cascade_en(cascade_en),
        .tok_in(rd_pass_in), .xfer(rd_go),
        .owner(rd_own), .slot(rd_slot), .tok_out(rtok)
    );

    assign wr_strobe = wr_go && wr_own;
    assign rd_strobe = rd_go && rd_own;

    // local occupancy for the half-full flag
    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else if (wr_strobe && !rd_strobe) occ_q <= occ_q + 1'b1;
        else if (rd_strobe && !wr_strobe) occ_q <= occ_q - 1'b1;
    end

    assign half_full = (occ_q > HALF);

    // shared pin: token pulse in cascade, half-full otherwise
    assign wr_pass_out = cascade_en ? wtok : half_full;
    assign rd_pass_out = rtok;

endmodule

// File: rtl/fill_tracker.sv
module fill_tracker
    import fifo_ring_pkg::*;
#(
    parameter int NUM_SLICES  = 4,
    parameter int SLICE_DEPTH = 8,
    localparam int CW = $clog2(NUM_SLICES * SLICE_DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cascade_en,
    input  logic wr_en,
    input  logic rd_en,
    output logic wr_go,
    output logic rd_go,
    output logic full,
    output logic empty
);

    localparam logic [CW-1:0] CAP_RING = CW'(NUM_SLICES * SLICE_DEPTH);
    localparam logic [CW-1:0] CAP_ONE  = CW'(SLICE_DEPTH);

    fill_state_t   state_q, state_d;
    logic [CW-1:0] count_q;
    logic [CW-1:0] cap;

    assign cap = cascade_en ? CAP_RING : CAP_ONE;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)               count_q <= '0;
        else if (wr_go && !rd_go) count_q <= count_q + 1'b1;
        else if (rd_go && !wr_go) count_q <= count_q - 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_EMPTY: if (wr_go) state_d = FL_MID;
            FL_MID: begin
                if (wr_go && !rd_go && count_q == cap - 1'b1)      state_d = FL_FULL;
                else if (rd_go && !wr_go && count_q == CW'(1))     state_d = FL_EMPTY;
            end
            FL_FULL:  if (rd_go) state_d = FL_MID;
            default:  state_d = FL_EMPTY;
        endcase
    end

    always_comb begin
        full  = (state_q == FL_FULL);
        empty = (state_q == FL_EMPTY);
        wr_go = wr_en && !full;
        rd_go = rd_en && !empty;
    end

endmodule

// File: rtl/fifo_ring_ctrl.sv
module fifo_ring_ctrl #(
    parameter int NUM_SLICES  = 4,
    parameter int SLICE_DEPTH = 8,
    localparam int AW    = $clog2(SLICE_DEPTH),
    localparam int SEL_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cascade_en,
    input  logic [SEL_W-1:0]      lead_sel,
    input  logic                  wr_en,
    input  logic                  rd_en,
    output logic [NUM_SLICES-1:0] wr_slice_en,
    output logic [AW-1:0]         wr_addr,
    output logic [NUM_SLICES-1:0] rd_slice_en,
    output logic [AW-1:0]         rd_addr,
    output logic                  full,
    output logic                  empty,
    output logic [NUM_SLICES-1:0] wr_pass_out,
    output logic [NUM_SLICES-1:0] rd_pass_out
);

    logic                  wr_go, rd_go;
    logic [NUM_SLICES-1:0] wr_own, rd_own;
    logic [AW-1:0]         wslot [NUM_SLICES];
    logic [AW-1:0]         rslot [NUM_SLICES];

    fill_tracker #(.NUM_SLICES(NUM_SLICES), .SLICE_DEPTH(SLICE_DEPTH)) u_fill (
        .clk(clk), .rst_n(rst_n), .cascade_en(cascade_en),
        .wr_en(wr_en), .rd_en(rd_en),
        .wr_go(wr_go), .rd_go(rd_go), .full(full), .empty(empty)
    );

    for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
        localparam int PREV = (g + NUM_SLICES - 1) % NUM_SLICES;
        ring_slice #(.DEPTH(SLICE_DEPTH)) u_slice (
            .clk(clk), .rst_n(rst_n),
            .lead(lead_sel == SEL_W'(g)),
            .cascade_en(cascade_en),
            .wr_pass_in(wr_pass_out[PREV]),
            .rd_pass_in(rd_pass_out[PREV]),
            .wr_go(wr_go), .rd_go(rd_go),
            .wr_own(wr_own[g]), .rd_own(rd_own[g]),
            .wr_strobe(wr_slice_en[g]), .rd_strobe(rd_slice_en[g]),
            .wr_slot(wslot[g]), .rd_slot(rslot[g]),
            .wr_pass_out(wr_pass_out[g]), .rd_pass_out(rd_pass_out[g])
        );
    end

    // slot of whichever slice owns each token
    always_comb begin
        wr_addr = '0;
        rd_addr = '0;
        for (int i = 0; i < NUM_SLICES; i++) begin
            if (wr_own[i]) wr_addr = wr_addr | wslot[i];
            if (rd_own[i]) rd_addr = rd_addr | rslot[i];
        end
    end

endmodule

// File: rtl/fifo_ring_ctrl_checker.sv
module fifo_ring_ctrl_checker #(
    parameter int NUM_SLICES  = 4,
    parameter int SLICE_DEPTH = 8,
    localparam int AW = $clog2(SLICE_DEPTH)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cascade_en,
    input logic [NUM_SLICES-1:0] wr_slice_en,
    input logic [AW-1:0]         wr_addr,
    input logic [NUM_SLICES-1:0] rd_slice_en,
    input logic [AW-1:0]         rd_addr,
    input logic                  full,
    input logic                  empty,
    input logic [NUM_SLICES-1:0] wr_pass_out,
    input logic [NUM_SLICES-1:0] rd_pass_out
);

    localparam logic [AW-1:0] SLOT_LAST = AW'(SLICE_DEPTH - 1);

    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wr_slice_en)); // R2
    AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rd_slice_en)); // R2
    AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_slice_en != '0 && wr_addr != SLOT_LAST) |=> wr_addr == $past(wr_addr) + 1'b1); // R2
    AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_slice_en != '0 && rd_addr != SLOT_LAST) |=> rd_addr == $past(rd_addr) + 1'b1); // R2
    AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n) full |-> wr_slice_en == '0); // R5
    AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) empty |-> rd_slice_en == '0); // R5
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(full && empty)); // R5
    AST_WPASS_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_en && wr_pass_out != '0) |-> (wr_slice_en == wr_pass_out && wr_addr == SLOT_LAST)); // R3
    AST_RPASS_WITH_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_en && rd_pass_out != '0) |-> (rd_slice_en == rd_pass_out && rd_addr == SLOT_LAST)); // R4
    AST_STANDALONE_RPASS: assert property (@(posedge clk) disable iff (!rst_n)
        !cascade_en |-> rd_pass_out == '0); // R7

endmodule

bind fifo_ring_ctrl fifo_ring_ctrl_checker #(
    .NUM_SLICES(NUM_SLICES), .SLICE_DEPTH(SLICE_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cascade_en(cascade_en),
    .wr_slice_en(wr_slice_en), .wr_addr(wr_addr),
    .rd_slice_en(rd_slice_en), .rd_addr(rd_addr),
    .full(full), .empty(empty),
    .wr_pass_out(wr_pass_out), .rd_pass_out(rd_pass_out)
);

// File: tb/tb_fifo_ring_ctrl.sv
module tb_fifo_ring_ctrl;

    localparam int N  = 4;
    localparam int D  = 8;
    localparam int AW = $clog2(D);
    localparam int SW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cascade_en = 1'b1;
    logic [SW-1:0] lead_sel = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [N-1:0]  wr_slice_en, rd_slice_en, wr_pass_out, rd_pass_out;
    logic [AW-1:0] wr_addr, rd_addr;
    logic          full, empty;

    fifo_ring_ctrl #(.NUM_SLICES(N), .SLICE_DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n), .cascade_en(cascade_en), .lead_sel(lead_sel),
        .wr_en(wr_en), .rd_en(rd_en),
        .wr_slice_en(wr_slice_en), .wr_addr(wr_addr),
        .rd_slice_en(rd_slice_en), .rd_addr(rd_addr),
        .full(full), .empty(empty),
        .wr_pass_out(wr_pass_out), .rd_pass_out(rd_pass_out)
    );

    always #4 clk = ~clk;

    int nchk = 0, nerr = 0;
    bit finished = 0;

    // bench model
    int m_wown, m_waddr, m_rown, m_raddr, m_cnt, m_wseq, m_rseq;
    int m_occ [N];
    int m_mem [N][D];
    bit m_casc;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int cap_of();
        return m_casc ? N * D : D;
    endfunction

    function automatic logic [N-1:0] sel_of(input bit go, input int idx);
        return go ? N'(1) << idx : '0;
    endfunction

    function automatic logic [N-1:0] exp_wpass(input bit wa);
        logic [N-1:0] v = '0;
        if (m_casc) return (wa && m_waddr == D - 1) ? N'(1) << m_wown : '0;
        for (int i = 0; i < N; i++) v[i] = (m_occ[i] > D / 2);
        return v;
    endfunction

    function automatic logic [N-1:0] exp_rpass(input bit ra);
        if (!m_casc) return '0;
        return (ra && m_raddr == D - 1) ? N'(1) << m_rown : '0;
    endfunction

    task automatic do_reset(input bit casc, input int lead);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 0; rd_en = 0;
        cascade_en = casc; lead_sel = SW'(lead);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_casc = casc; m_wown = lead; m_rown = lead;
        m_waddr = 0; m_raddr = 0; m_cnt = 0; m_wseq = 0; m_rseq = 0;
        for (int i = 0; i < N; i++) m_occ[i] = 0;
        #1;
        chk(empty == 1'b1, "R1 empty after reset", empty, 1);
        chk(full == 1'b0, "R1 full after reset", full, 0);
        chk(wr_addr == 0 && rd_addr == 0, "R1 addresses after reset", {wr_addr, rd_addr}, 0);
        if (casc) chk(wr_pass_out == 0 && rd_pass_out == 0, "R1 no pass after reset",
                      {wr_pass_out, rd_pass_out}, 0);
    endtask

    task automatic step(input bit we, input bit re);
        bit xfull, xempty, wa, ra;
        string ptag;
        @(negedge clk);
        wr_en = we; rd_en = re;
        #1;
        xfull = (m_cnt == cap_of()); xempty = (m_cnt == 0);
        wa = we && !xfull; ra = re && !xempty;
        chk(full == xfull, "R5 full flag", full, xfull);
        chk(empty == xempty, "R5 empty flag", empty, xempty);
        chk(wr_slice_en == sel_of(wa, m_wown), "R2 write strobe", wr_slice_en, sel_of(wa, m_wown));
        chk(rd_slice_en == sel_of(ra, m_rown), "R2 read strobe", rd_slice_en, sel_of(ra, m_rown));
        chk(int'(wr_addr) == m_waddr, "R2 write slot", wr_addr, m_waddr);
        chk(int'(rd_addr) == m_raddr, "R2 read slot", rd_addr, m_raddr);
        ptag = !m_casc ? "R7 wr pass/half-full" : (exp_wpass(wa) != 0 ? "R3 write pass" : "R8 no write pass");
        chk(wr_pass_out == exp_wpass(wa), ptag, wr_pass_out, exp_wpass(wa));
        ptag = !m_casc ? "R7 rd pass zero" : (exp_rpass(ra) != 0 ? "R4 read pass" : "R8 no read pass");
        chk(rd_pass_out == exp_rpass(ra), ptag, rd_pass_out, exp_rpass(ra));
        if (ra) begin
            chk(m_mem[m_rown][m_raddr] == m_rseq, "R6 read order", m_mem[m_rown][m_raddr], m_rseq);
            m_rseq++;
            m_occ[m_rown]--;
            if (m_raddr == D - 1) begin
                m_raddr = 0;
                if (m_casc) m_rown = (m_rown + 1) % N;
            end else m_raddr++;
        end
        if (wa) begin
            m_mem[m_wown][m_waddr] = m_wseq;
            m_wseq++;
            m_occ[m_wown]++;
            if (m_waddr == D - 1) begin
                m_waddr = 0;
                if (m_casc) m_wown = (m_wown + 1) % N;
            end else m_waddr++;
        end
        m_cnt = m_cnt + (wa ? 1 : 0) - (ra ? 1 : 0);
    endtask

    task automatic random_phase(input int cycles, input int pw, input int pr);
        for (int k = 0; k < cycles; k++)
            step(($urandom % 100) < pw, ($urandom % 100) < pr);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        // R1/R3/R4/R5: lead slice 2, full ring wrap 3 -> 0
        do_reset(1'b1, 2);
        step(0, 0);
        for (int k = 0; k < N * D; k++) step(1, 0);
        step(1, 0);                    // R5 write at full ignored
        step(1, 1);                    // read and write together at full
        for (int k = 0; k < N * D; k++) step(0, 1);
        step(0, 1);                    // R5 read at empty ignored
        step(1, 1);                    // both at empty: write only
        step(0, 1);
        random_phase(1500, 70, 40);
        random_phase(1500, 40, 70);
        random_phase(1000, 55, 55);
        // lead slice 3 so the first pass wraps to slice 0 (R3)
        do_reset(1'b1, 3);
        random_phase(800, 80, 30);
        random_phase(800, 30, 80);
        // R7: standalone, lead slice 1
        do_reset(1'b0, 1);
        for (int k = 0; k < D; k++) step(1, 0);
        step(1, 0);
        for (int k = 0; k < D; k++) step(0, 1);
        random_phase(1000, 55, 50);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule